// File: doc/BRIEF.md
# Configurable Registered Fan-out Buffer

This block is a bank of clocked registers placed between a memory controller's address and command bus and the memory devices it drives. It runs in one of two modes, chosen while it operates. In straight mode a 25-bit input word is captured one-to-one on each rising clock edge. In fan-out mode only the low 14 input bits are captured, and each captured bit drives two outputs. Two output layouts are available in fan-out mode: a shifted copy and a mirrored copy.

Two select inputs gate the register. When both are high the outputs keep their value on the clock edge, and when either is low new data is captured. An active-low reset clears the outputs at once, whatever the clock is doing, and wins over the gating. Reset release passes through a two-stage synchronizer. For a parameterized window after that, the data inputs are treated as zero, which models the delay of the input receivers. The outputs therefore leave reset low and without glitches, even if the data pins are not yet valid.

Top module: `rfbBuffer`

## Requirements
- R1: With `pairMode` low, `dataOut[i]` equals `dataIn[i]` for i in 0..24 one clock edge after capture, and `mapSwap` has no effect.
- R2: With `pairMode` low, `dataOut[27:25]` are driven low.
- R3: With `pairMode` high and `mapSwap` low (shifted layout), `dataOut[i]` and `dataOut[i+14]` both equal `dataIn[i]` for i in 0..13, and `dataIn[24:14]` is ignored.
- R4: With `pairMode` high and `mapSwap` high (mirrored layout), `dataOut[i]` and `dataOut[27-i]` both equal `dataIn[i]` for i in 0..13.
- R5: While `rstN` is low, `dataOut` is all zero, and it goes to zero as soon as `rstN` falls, without waiting for a clock edge.
- R6: On a clock edge where `selA` and `selB` are both high, `dataOut` keeps its value, even if the data or the mode inputs change.
- R7: On a clock edge where at least one of `selA` and `selB` is low, the word is captured normally.
- R8: An asserted reset clears `dataOut` even while both selects are high.
- R9: After `rstN` rises, `dataOut` stays zero for the first 2+MASK_CYC clock edges (2 synchronizer edges, then MASK_CYC edges during which the data inputs are forced to zero), even with nonzero data. The next edge captures `dataIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| pairMode | input | 1 | 0: straight 25-bit mode, 1: 14-bit fan-out mode |
| mapSwap | input | 1 | Fan-out layout: 0 shifted, 1 mirrored |
| selA | input | 1 | First select; gating when both selects are high |
| selB | input | 1 | Second select; gating when both selects are high |
| dataIn | input | 25 | Input word |
| dataOut | output | 28 | Registered output word |

## Verification
The assertions check on every clock edge that gated edges leave the outputs unchanged, that the outputs are zero whenever reset is low, that the unused high outputs stay low in straight mode, and that paired outputs agree in both fan-out layouts. They do not check that the captured values are the right input bits. The bench scenarios show that: exact output words across mode and select patterns, the input bits ignored in fan-out mode, immediate clearing when reset falls mid-cycle, and the exact edge on which data first appears after reset release.

// File: rtl/rfbPkg.sv
package rfbPkg;
  typedef struct packed {
    logic clear;   // synchronous hold-at-zero while release is synchronizing
    logic load;    // capture enable (select gating applied)
    logic zeroIn;  // treat data inputs as zero (receiver wake window)
  } rfbStrobe_t;
endpackage

// File: rtl/rfbControl.sv
module rfbControl
  import rfbPkg::*;
#(
  parameter int MASK_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selA,
  input  logic       selB,
  output rfbStrobe_t strobe
);
  localparam int CNT_W = (MASK_CYC > 0) ? $clog2(MASK_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MASK_CYC);

  logic syncA, syncB;
  logic [CNT_W-1:0] wakeCnt;
  logic ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= 1'b1;
      syncB <= syncA;
    end
  end

  assign ready = syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (ready && (wakeCnt < CNT_MAX)) begin
      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.clear  = !ready;
    strobe.load   = ready && !(selA && selB);
    strobe.zeroIn = !ready || (wakeCnt < CNT_MAX);
  end

  // R9: the wake window is still open on the first edge after sync completes
  assert_wake_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> strobe.zeroIn);
endmodule

// File: rtl/rfbDatapath.sv
module rfbDatapath
  import rfbPkg::*;
#(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14,
  parameter int OUT_W  = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  rfbStrobe_t       strobe,
  input  logic             pairMode,
  input  logic             mapSwap,
  input  logic [IN_W-1:0]  dataIn,
  output logic [OUT_W-1:0] dataOut
);
  logic [OUT_W-1:0] straightW, shiftW, mirrorW, nextW, outQ;

  for (genvar j = 0; j < OUT_W; j++) begin : g_map
    localparam int SRC_SHIFT  = j % HALF_W;
    localparam int SRC_MIRROR = (j < HALF_W) ? j : (OUT_W - 1 - j);
    if (j < IN_W) begin : g_used
      assign straightW[j] = dataIn[j];
    end else begin : g_unused
      assign straightW[j] = 1'b0;
    end
    assign shiftW[j]  = dataIn[SRC_SHIFT];
    assign mirrorW[j] = dataIn[SRC_MIRROR];
  end

  always_comb begin
    if (!pairMode)    nextW = straightW;
    else if (mapSwap) nextW = mirrorW;
    else              nextW = shiftW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else if (strobe.clear) begin
      outQ <= '0;
    end else if (strobe.load) begin
      outQ <= strobe.zeroIn ? '0 : nextW;
    end
  end

  assign dataOut = outQ;

  // R2: straight-mode capture leaves the spare outputs low
  assert_spare_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !pairMode) |=> (dataOut[OUT_W-1:IN_W] == '0));

  for (genvar i = 0; i < HALF_W; i++) begin : g_chk
    // R3: shifted layout drives equal pairs i and i+HALF_W
    assert_shift_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && pairMode && !mapSwap) |=> (dataOut[i] == dataOut[i+HALF_W]));
    // R4: mirrored layout drives equal pairs i and OUT_W-1-i
    assert_mirror_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && pairMode && mapSwap) |=> (dataOut[i] == dataOut[OUT_W-1-i]));
  end
endmodule

// File: rtl/rfbBuffer.sv
module rfbBuffer
  import rfbPkg::*;
#(
  parameter int IN_W     = 25,
  parameter int HALF_W   = 14,
  parameter int MASK_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pairMode,
  input  logic                  mapSwap,
  input  logic                  selA,
  input  logic                  selB,
  input  logic [IN_W-1:0]       dataIn,
  output logic [2*HALF_W-1:0]   dataOut
);
  localparam int OUT_W = 2 * HALF_W;

  rfbStrobe_t strobe;

  rfbControl #(.MASK_CYC(MASK_CYC)) i_control (
    .clk    (clk),
    .rstN   (rstN),
    .selA   (selA),
    .selB   (selB),
    .strobe (strobe)
  );

  rfbDatapath #(.IN_W(IN_W), .HALF_W(HALF_W), .OUT_W(OUT_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pairMode (pairMode),
    .mapSwap  (mapSwap),
    .dataIn   (dataIn),
    .dataOut  (dataOut)
  );

  // R6: a gated edge leaves every output unchanged
  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selA && selB) |=> $stable(dataOut));

  // R5 and R8: reset low means zero outputs, gating or not
  assert_reset_zero_R5: assert property (@(posedge clk)
    (!rstN) |-> (dataOut == '0));
endmodule

// File: tb/test_rfbBuffer.sv
module test_rfbBuffer;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 25;
  localparam int HALF_W = 14;
  localparam int OUT_W = 28;
  localparam int MASK_CYC = 4;

  typedef struct packed {
    logic pm; logic sw; logic sa; logic sb; logic [IN_W-1:0] d;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 25'h1ABCDEF},
    '{1'b0, 1'b0, 1'b1, 1'b0, 25'h0F0F0F0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 25'h1FFFFFF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 25'h0002A5C},
    '{1'b1, 1'b0, 1'b0, 1'b0, 25'h1FFC000},
    '{1'b1, 1'b1, 1'b0, 1'b0, 25'h0001234},
    '{1'b1, 1'b1, 1'b1, 1'b1, 25'h1FFFFFF},
    '{1'b0, 1'b0, 1'b1, 1'b1, 25'h0000000},
    '{1'b1, 1'b1, 1'b0, 1'b1, 25'h0003FFF},
    '{1'b0, 1'b1, 1'b0, 1'b0, 25'h1555555},
    '{1'b1, 1'b0, 1'b1, 1'b1, 25'h0000000},
    '{1'b1, 1'b0, 1'b1, 1'b0, 25'h0000001}
  };

  logic clk = 1'b0;
  logic rstN, pairMode, mapSwap, selA, selB;
  logic [IN_W-1:0] dataIn;
  logic [OUT_W-1:0] dataOut;
  int total = 0;
  int failed = 0;
  logic [OUT_W-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfbBuffer #(.IN_W(IN_W), .HALF_W(HALF_W), .MASK_CYC(MASK_CYC)) i_rfbBuffer (
    .clk(clk), .rstN(rstN), .pairMode(pairMode), .mapSwap(mapSwap),
    .selA(selA), .selB(selB), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic [OUT_W-1:0] expectOf(logic pm, logic sw, logic [IN_W-1:0] d);
    logic [OUT_W-1:0] r;
    r = '0;
    if (!pm) begin
      for (int k = 0; k < IN_W; k++) r[k] = d[k];
    end else begin
      for (int k = 0; k < HALF_W; k++) begin
        r[k] = d[k];
        if (sw) r[OUT_W-1-k] = d[k];
        else    r[k+HALF_W]  = d[k];
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: dataOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic pm, logic sw, logic sa, logic sb, logic [IN_W-1:0] d);
    pairMode = pm; mapSwap = sw; selA = sa; selB = sb; dataIn = d;
  endtask

  // releases reset at a negedge, then runs through sync and wake window
  task automatic releaseAndSettle();
    rstN = 1'b1;
    repeat (2 + MASK_CYC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: dataOut=%h expected=run completion", dataOut);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    @(negedge clk);
    check("R5 reset state", dataOut, '0);

    // R9: nonzero data at release must stay invisible for 2+MASK_CYC edges
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFFFFF);
    rstN = 1'b1;
    for (int e = 1; e <= 2 + MASK_CYC; e++) begin
      @(negedge clk);
      check($sformatf("R9 wake edge %0d", e), dataOut, '0);
    end
    @(negedge clk);
    check("R9 first capture", dataOut, expectOf(1'b0, 1'b0, 25'h1FFFFFF));
    model = dataOut;

    // table walk: R1 R2 R3 R4 R6 R7
    model = expectOf(1'b0, 1'b0, 25'h1FFFFFF);
    for (int v = 0; v < 12; v++) begin
      string tag;
      drive(VECS[v].pm, VECS[v].sw, VECS[v].sa, VECS[v].sb, VECS[v].d);
      @(negedge clk);
      if (!(VECS[v].sa && VECS[v].sb)) model = expectOf(VECS[v].pm, VECS[v].sw, VECS[v].d);
      if (VECS[v].sa && VECS[v].sb)      tag = "R6 gated hold";
      else if (VECS[v].sa || VECS[v].sb) tag = "R7 one select low";
      else if (!VECS[v].pm)              tag = "R1 straight";
      else if (VECS[v].sw)               tag = "R4 mirrored";
      else                               tag = "R3 shifted";
      check($sformatf("%s vec %0d", tag, v), dataOut, model);
      if (!VECS[v].pm && !(VECS[v].sa && VECS[v].sb))
        check("R2 spare outputs", {dataOut[OUT_W-1:IN_W], {IN_W{1'b0}}}, '0);
    end

    // R3: upper input bits ignored in shifted fan-out
    drive(1'b1, 1'b0, 1'b0, 1'b0, 25'h1FFC000);
    @(negedge clk);
    check("R3 upper input ignored", dataOut, '0);

    // R5: asynchronous clear in mid cycle
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h0ABCDEF);
    @(negedge clk);
    check("R1 before async reset", dataOut, expectOf(1'b0, 1'b0, 25'h0ABCDEF));
    @(posedge clk);
    #1;
    rstN = 1'b0;
    #1;
    check("R5 async clear", dataOut, '0);
    @(negedge clk);
    releaseAndSettle();
    check("R1 after re-release", dataOut, expectOf(1'b0, 1'b0, 25'h0ABCDEF));

    // R8: reset wins over gating
    drive(1'b1, 1'b1, 1'b1, 1'b1, 25'h0000000);
    @(negedge clk);
    check("R6 hold before reset", dataOut, expectOf(1'b0, 1'b0, 25'h0ABCDEF));
    rstN = 1'b0;
    #1;
    check("R8 reset while gated", dataOut, '0);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 25'h0003FFF);
    releaseAndSettle();
    check("R8 gated after release stays zero", dataOut, '0);
    selB = 1'b0;
    @(negedge clk);
    check("R4 capture after ungating", dataOut, expectOf(1'b1, 1'b1, 25'h0003FFF));

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule